// File: doc/BRIEF.md
# Receive FIFO Interrupt and Timeout Controller

This block supervises a 16-entry receive FIFO while a serial receiver runs in FIFO mode. It sees the FIFO occupancy, a strobe for each character written into the FIFO, a strobe for each character the CPU takes out, and a tick once per receive bit time. From these inputs it derives four outputs: the data-ready status bit, a received-data-available interrupt tied to a programmable trigger level, a character timeout interrupt, and the interrupt identification code.

The timeout catches a FIFO that holds data below the trigger level and has gone quiet. The block counts receive bit times since the last event, where an event is either a received character or a CPU read. It raises the timeout once that count reaches four character times and the FIFO is not empty. A character time is the number of bits in one frame under the current character length, parity and stop-bit settings, so the delay follows the baud rate. A line-status request from outside outranks both interrupts in the identification code. Every output is registered.

Top module: `rx_fifo_irq_ctrl`

## Requirements
- R1: When the FIFO enable or the receive-interrupt enable is 0, rdaIrq and timeoutIrq are 0 one cycle later, whatever the count and the timer.
- R2: The trigger select maps 2'b00, 2'b01, 2'b10 and 2'b11 to 1, 4, 8 and 14 characters. When both enables are 1, rdaIrq is 1 one cycle after fifoCount is at or above the selected level, and it is 0 one cycle after fifoCount falls below that level.
- R3: dataReady is 1 one cycle after a cycle with charRcvd high. It is 0 one cycle after a cycle in which fifoCount is 0 and charRcvd is low. Otherwise it holds its value.
- R4: The timeout threshold is 4 × (1 start + (5 + wordLen) data + parityEn + (1 + twoStop) stop) bit ticks, where wordLen 2'b00 to 2'b11 means 5 to 8 data bits. Only cycles with bitTick high advance the age. timeoutIrq is 1 one cycle after a cycle in which the age has reached the threshold, both enables are 1, fifoCount is nonzero, and neither strobe is high.
- R5: A cycle with cpuRead or charRcvd high clears timeoutIrq on the next edge and restarts the age at 0.
- R6: While fifoCount is 0, timeoutIrq stays 0 and the age is held at 0.
- R7: irqId is registered and ranks its sources as follows: lineIrq gives 4'h6, then timeout gives 4'hC, then received-data-available gives 4'h4, and with no source it gives 4'h1.
- R8: After reset, dataReady, rdaIrq and timeoutIrq are 0 and irqId is 4'h1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fifoEn | input | 1 | FIFO mode enable |
| rxIrqEn | input | 1 | Receive interrupt enable |
| lineIrq | input | 1 | Qualified line-status interrupt request |
| fifoCount | input | 5 | Characters held in the receive FIFO (0 to 16) |
| charRcvd | input | 1 | One-cycle strobe: a character entered the FIFO |
| cpuRead | input | 1 | One-cycle strobe: the CPU read a character |
| bitTick | input | 1 | One pulse per receive bit time |
| wordLen | input | 2 | Data bits per character, 2'b00 to 2'b11 = 5 to 8 |
| parityEn | input | 1 | Parity bit present |
| twoStop | input | 1 | Two stop bits |
| trigSel | input | 2 | Trigger level select |
| dataReady | output | 1 | Receive data-ready status bit |
| rdaIrq | output | 1 | Received-data-available interrupt |
| timeoutIrq | output | 1 | Character timeout interrupt |
| irqId | output | 4 | Interrupt identification code |

## Verification
Every output comes from a register. Its value is therefore due on the first rising edge after the cycle in which its inputs were presented. The timeout is due one edge after the cycle whose age has reached the threshold, so it appears two edges after the tick that completes the count. The bench drives inputs on the falling edge. For each driven cycle it computes the expected outputs from the requirements and queues them. A monitor pops each item 1 ns after the next rising edge, so each result is compared in exactly the cycle it is due. Threshold arithmetic is covered by timeout runs at the shortest and longest frame settings, one of them with sparse ticks.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;

  // Identification codes, ranked line > timeout > data available > none
  localparam logic [3:0] ID_NONE    = 4'h1;
  localparam logic [3:0] ID_DATA    = 4'h4;
  localparam logic [3:0] ID_LINE    = 4'h6;
  localparam logic [3:0] ID_TIMEOUT = 4'hC;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic enable;    // both enables set
    logic levelHit;  // count at or above trigger level
    logic nonEmpty;  // FIFO holds a character
    logic rcvd;      // character entered FIFO this cycle
    logic quiet;     // neither receive nor read this cycle
    logic timerClr;  // restart the age counter
    logic timerInc;  // advance the age counter
  } ctrlStrobes_t;

endpackage

// File: rtl/rxirq_cfg.sv
module rxirq_cfg #(
  parameter int CNT_W = 5,
  parameter int TMR_W = 6,
  parameter int LVL_A = 1,
  parameter int LVL_B = 4,
  parameter int LVL_C = 8,
  parameter int LVL_D = 14
) (
  input  logic [1:0]       wordLen,
  input  logic             parityEn,
  input  logic             twoStop,
  input  logic [1:0]       trigSel,
  output logic [CNT_W-1:0] trigLevel,
  output logic [TMR_W-1:0] timeoutThr
);

  // start + 5 data + 1 stop is the shortest frame
  localparam logic [3:0] BASE_BITS = 4'd7;

  logic [3:0] bitsPerChar;

  always_comb begin
    bitsPerChar = BASE_BITS + {2'b00, wordLen} + {3'b000, parityEn}
                + {3'b000, twoStop};
    timeoutThr  = TMR_W'({bitsPerChar, 2'b00});
  end

  always_comb begin
    unique case (trigSel)
      2'b00:   trigLevel = CNT_W'(LVL_A);
      2'b01:   trigLevel = CNT_W'(LVL_B);
      2'b10:   trigLevel = CNT_W'(LVL_C);
      default: trigLevel = CNT_W'(LVL_D);
    endcase
  end

endmodule

// File: rtl/rxirq_ctrl.sv
module rxirq_ctrl
  import rxirq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             fifoEn,
  input  logic             rxIrqEn,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic             charRcvd,
  input  logic             cpuRead,
  input  logic             bitTick,
  input  logic [CNT_W-1:0] trigLevel,
  output ctrlStrobes_t     strb
);

  logic activity;

  always_comb begin
    activity      = charRcvd | cpuRead;
    strb.enable   = fifoEn & rxIrqEn;
    strb.levelHit = fifoCount >= trigLevel;
    strb.nonEmpty = fifoCount != '0;
    strb.rcvd     = charRcvd;
    strb.quiet    = ~activity;
    // age is meaningful only while data waits in the FIFO
    strb.timerClr = activity | ~strb.nonEmpty;
    strb.timerInc = bitTick;
  end

endmodule

// File: rtl/rxirq_dp.sv
module rxirq_dp
  import rxirq_pkg::*;
#(
  parameter int TMR_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic [TMR_W-1:0] timeoutThr,
  input  logic             lineIrq,
  output logic             dataReady,
  output logic             rdaIrq,
  output logic             timeoutIrq,
  output logic [3:0]       irqId
);

  localparam logic [TMR_W-1:0] AGE_MAX = '1;

  logic [TMR_W-1:0] ageCnt;
  logic             nextRda;
  logic             nextTout;
  logic [3:0]       nextId;

  // age in bit ticks since the last receive or read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  ageCnt <= '0;
    else if (strb.timerClr)                     ageCnt <= '0;
    else if (strb.timerInc && ageCnt != AGE_MAX) ageCnt <= ageCnt + 1'b1;
  end

  always_comb begin
    nextRda  = strb.enable & strb.levelHit;
    nextTout = strb.enable & strb.nonEmpty & strb.quiet & (ageCnt >= timeoutThr);
    if (lineIrq)       nextId = ID_LINE;
    else if (nextTout) nextId = ID_TIMEOUT;
    else if (nextRda)  nextId = ID_DATA;
    else               nextId = ID_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdaIrq     <= 1'b0;
      timeoutIrq <= 1'b0;
      irqId      <= ID_NONE;
    end else begin
      rdaIrq     <= nextRda;
      timeoutIrq <= nextTout;
      irqId      <= nextId;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               dataReady <= 1'b0;
    else if (strb.rcvd)      dataReady <= 1'b1;
    else if (!strb.nonEmpty) dataReady <= 1'b0;
  end

  assert_enable_gate_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strb.enable |=> (!rdaIrq && !timeoutIrq));

  assert_ready_on_char_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.rcvd |=> dataReady);

  assert_ready_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.nonEmpty && !strb.rcvd) |=> !dataReady);

  assert_timeout_age_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutIrq) |-> ($past(ageCnt) >= $past(timeoutThr)));

  assert_activity_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.quiet |=> !timeoutIrq);

  assert_empty_no_timeout_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.nonEmpty |=> !timeoutIrq);

  assert_line_first_R7: assert property (@(posedge clk) disable iff (!rstN)
    lineIrq |=> (irqId == ID_LINE));

endmodule

// File: rtl/rx_fifo_irq_ctrl.sv
module rx_fifo_irq_ctrl
  import rxirq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_A      = 1,
  parameter int LVL_B      = 4,
  parameter int LVL_C      = 8,
  parameter int LVL_D      = 14
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               fifoEn,
  input  logic                               rxIrqEn,
  input  logic                               lineIrq,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0]    fifoCount,
  input  logic                               charRcvd,
  input  logic                               cpuRead,
  input  logic                               bitTick,
  input  logic [1:0]                         wordLen,
  input  logic                               parityEn,
  input  logic                               twoStop,
  input  logic [1:0]                         trigSel,
  output logic                               dataReady,
  output logic                               rdaIrq,
  output logic                               timeoutIrq,
  output logic [3:0]                         irqId
);

  localparam int CNT_W    = $clog2(FIFO_DEPTH + 1);
  localparam int MAX_BITS = 12;  // start + 8 data + parity + 2 stop
  localparam int TMR_W    = $clog2(4 * MAX_BITS + 1);

  logic [CNT_W-1:0] trigLevel;
  logic [TMR_W-1:0] timeoutThr;
  ctrlStrobes_t     strb;

  rxirq_cfg #(
    .CNT_W(CNT_W), .TMR_W(TMR_W),
    .LVL_A(LVL_A), .LVL_B(LVL_B), .LVL_C(LVL_C), .LVL_D(LVL_D)
  ) u_cfg (
    .wordLen   (wordLen),
    .parityEn  (parityEn),
    .twoStop   (twoStop),
    .trigSel   (trigSel),
    .trigLevel (trigLevel),
    .timeoutThr(timeoutThr)
  );

  rxirq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .fifoEn   (fifoEn),
    .rxIrqEn  (rxIrqEn),
    .fifoCount(fifoCount),
    .charRcvd (charRcvd),
    .cpuRead  (cpuRead),
    .bitTick  (bitTick),
    .trigLevel(trigLevel),
    .strb     (strb)
  );

  rxirq_dp #(.TMR_W(TMR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .timeoutThr(timeoutThr),
    .lineIrq   (lineIrq),
    .dataReady (dataReady),
    .rdaIrq    (rdaIrq),
    .timeoutIrq(timeoutIrq),
    .irqId     (irqId)
  );

endmodule

// File: tb/rx_fifo_irq_ctrl_tb.sv
module rx_fifo_irq_ctrl_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fifoEn = 1'b0, rxIrqEn = 1'b0, lineIrq = 1'b0;
  logic [4:0] fifoCount = '0;
  logic       charRcvd = 1'b0, cpuRead = 1'b0, bitTick = 1'b0;
  logic [1:0] wordLen = 2'b00;
  logic       parityEn = 1'b0, twoStop = 1'b0;
  logic [1:0] trigSel = 2'b00;
  logic       dataReady, rdaIrq, timeoutIrq;
  logic [3:0] irqId;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic       dr, rda, tout;
    logic [3:0] id;
    string      tagRda, tagTout;
  } expItem_t;

  expItem_t sbQ[$];

  int   mAge = 0;
  logic mDr  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  rx_fifo_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .rxIrqEn(rxIrqEn),
    .lineIrq(lineIrq), .fifoCount(fifoCount), .charRcvd(charRcvd),
    .cpuRead(cpuRead), .bitTick(bitTick), .wordLen(wordLen),
    .parityEn(parityEn), .twoStop(twoStop), .trigSel(trigSel),
    .dataReady(dataReady), .rdaIrq(rdaIrq), .timeoutIrq(timeoutIrq),
    .irqId(irqId)
  );

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: model the requirements for the cycle now presented, queue result
  task automatic cyc();
    expItem_t e;
    bit en;
    int thr, lvl;
    en  = fifoEn && rxIrqEn;
    thr = 4 * (1 + 5 + int'(wordLen) + int'(parityEn) + 1 + int'(twoStop)); // R4
    case (trigSel)                                                            // R2
      2'b00: lvl = 1;
      2'b01: lvl = 4;
      2'b10: lvl = 8;
      default: lvl = 14;
    endcase
    e.rda  = en && (int'(fifoCount) >= lvl);
    e.tout = en && fifoCount != 0 && mAge >= thr && !charRcvd && !cpuRead;
    if (charRcvd) mDr = 1'b1;
    else if (fifoCount == 0) mDr = 1'b0;
    e.dr = mDr;
    if (lineIrq)     e.id = 4'h6;
    else if (e.tout) e.id = 4'hC;
    else if (e.rda)  e.id = 4'h4;
    else             e.id = 4'h1;
    e.tagRda  = en ? "R2" : "R1";
    if (!en)                       e.tagTout = "R1";
    else if (fifoCount == 0)       e.tagTout = "R6";
    else if (charRcvd || cpuRead)  e.tagTout = "R5";
    else                           e.tagTout = "R4";
    if (charRcvd || cpuRead || fifoCount == 0) mAge = 0;
    else if (bitTick && mAge < 63) mAge++;
    sbQ.push_back(e);
    @(negedge clk);
  endtask

  task automatic runTicks(int n, int every);
    for (int i = 0; i < n; i++) begin
      bitTick = (i % every) == 0;
      cyc();
    end
    bitTick = 1'b0;
  endtask

  // monitor: compare each queued item 1 ns after the edge it is due on
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbQ.size() > 0) begin
        expItem_t e;
        e = sbQ.pop_front();
        chk("R3 dataReady", {3'b0, dataReady}, {3'b0, e.dr});
        chk({e.tagRda, " rdaIrq"}, {3'b0, rdaIrq}, {3'b0, e.rda});
        chk({e.tagTout, " timeoutIrq"}, {3'b0, timeoutIrq}, {3'b0, e.tout});
        chk("R7 irqId", irqId, e.id);
      end
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 dataReady", {3'b0, dataReady}, 4'h0);
    chk("R8 rdaIrq", {3'b0, rdaIrq}, 4'h0);
    chk("R8 timeoutIrq", {3'b0, timeoutIrq}, 4'h0);
    chk("R8 irqId", irqId, 4'h1);

    fifoEn = 1; rxIrqEn = 1;
    // R2 and R3: fill toward level 4 and drain
    trigSel = 2'b01;
    for (int c = 0; c < 6; c++) begin
      charRcvd = 1; cyc(); charRcvd = 0; fifoCount = 5'(c + 1); cyc();
    end
    for (int c = 6; c > 0; c--) begin
      cpuRead = 1; cyc(); cpuRead = 0; fifoCount = 5'(c - 1); cyc();
    end
    cyc();
    // R2 other levels
    trigSel = 2'b11; fifoCount = 13; cyc(); fifoCount = 14; cyc(); fifoCount = 16; cyc();
    trigSel = 2'b10; fifoCount = 7;  cyc(); fifoCount = 8;  cyc();
    trigSel = 2'b00; fifoCount = 0;  cyc(); fifoCount = 1;  cyc();

    // R1 enables gate both interrupts
    fifoCount = 16; fifoEn = 0; runTicks(60, 1);
    fifoEn = 1; rxIrqEn = 0; runTicks(60, 1);
    rxIrqEn = 1; cyc();

    // R4 and R5: shortest frame, threshold 28
    trigSel = 2'b11; wordLen = 0; parityEn = 0; twoStop = 0;
    fifoCount = 3; charRcvd = 1; cyc(); charRcvd = 0;
    runTicks(34, 1);
    cpuRead = 1; cyc(); cpuRead = 0; fifoCount = 2;
    runTicks(31, 1);
    charRcvd = 1; cyc(); charRcvd = 0; fifoCount = 3;
    runTicks(5, 1);

    // R4, R7: longest frame, threshold 48, sparse ticks, data level met
    wordLen = 2'b11; parityEn = 1; twoStop = 1; trigSel = 2'b00;
    cpuRead = 1; cyc(); cpuRead = 0;
    runTicks(100, 2);
    lineIrq = 1; runTicks(3, 1); lineIrq = 0;
    cpuRead = 1; cyc(); cpuRead = 0;
    runTicks(4, 1);
    lineIrq = 1; cyc(); lineIrq = 0; cyc();

    // R6: empty FIFO never times out, and age restarts from empty
    wordLen = 0; parityEn = 0; twoStop = 0; trigSel = 2'b11;
    fifoCount = 0; runTicks(60, 1);
    fifoCount = 2; runTicks(32, 1);
    cyc(); cyc();

    repeat (2) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule